// File: doc/BRIEF.md
# Saturating Fixed-Point Shifter and Normalizer

This block is a combinational arithmetic unit for signed fixed-point words in two widths: a 16-bit narrow format and a 32-bit wide format. It does arithmetic shifts in either direction, a right shift with round-to-nearest, and a count of redundant sign bits. The shift count is a signed 16-bit number. A negative count turns the shift around. Any left shift that would lose significant bits is clamped to the largest positive or largest negative value of the selected width.

Each result comes from the current operand, count and opcode. A parameter can add one register stage on the result. A sticky overflow flag records that some left shift saturated. The flag stays set until an explicit clear or a reset, so software or a surrounding datapath can test once at the end of a run of operations.

Top module: `sshift_unit`

## Requirements
- R1: Opcode bits [1:0] select the function: 00 shift left, 01 shift right, 10 rounding shift right, 11 normalize. Bit 2 set selects wide mode, which uses operand[31:0]. Bit 2 clear selects narrow mode, which uses only operand[15:0] and returns a 16-bit result sign-extended to 32 bits.
- R2: A left shift by n happens in three cases: opcode 00 with count > 0, opcode 01 with count < 0, or opcode 10 with count < 0, where n is the count's magnitude. A zero operand gives 0. If n is not greater than the operand's normalize count, the result is operand·2^n. Otherwise the result is the most positive value for a non-negative operand and the most negative value for a negative operand.
- R3: A right shift happens for opcode 00 with count ≤ 0 and for opcode 01 with count ≥ 0. It shifts arithmetically by the count's magnitude. Magnitudes at or above the width minus one give 0 or -1, according to the sign.
- R4: The rounding shift (opcode 10, count n > 0) first shifts arithmetically by n-1. It then shifts by one more and adds the bit shifted out, so ties round upward. Counts at or above the width give 0.
- R5: The rounding shift with a zero count or a zero operand returns the operand unchanged, and does not saturate.
- R6: Normalize (opcode 11) returns the number of bits below the sign bit that equal the sign bit. This is 0 for a zero operand, 15 or 31 for -1, and always less than the width. The count is zero-extended.
- R7: A count of -32768 is handled as a magnitude of 32768. It gives a full right shift in one direction and saturation in the other, unless the operand is zero.
- R8: The overflow flag becomes 1 at the clock edge at which a saturating left shift is present on the inputs. Operations that do not saturate never set it. Once set, it holds.
- R9: With clear asserted, the flag is 0 after the next edge. If a saturation is present at that same edge, the set wins.
- R10: Reset clears the flag, and clears the result register when one is built. With OUT_REG=0 the result is combinational. With OUT_REG=1 the result appears one clock after its inputs.
- R11: Narrow-mode saturation gives 0x00007FFF or 0xFFFF8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag and the optional result register |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_ovf | input | 1 | Clears the sticky overflow flag |
| op | input | 3 | Function in [1:0], wide mode in [2] |
| operand | input | 32 | Data word; narrow mode uses bits [15:0] |
| count | input | 16 | Signed shift count |
| result | output | 32 | Shifted value or normalize count |
| ovf | output | 1 | Sticky saturation flag |

## Verification
With the default OUT_REG=0, the result depends only on the present inputs. The bench drives inputs on the falling edge and reads the result a couple of nanoseconds later, before any rising edge can matter. The overflow flag changes at the first rising edge after a saturating input, so it is read at the next falling edge. The bench clears the flag in the cycle before each vector so that the flag reflects that one vector alone. A second instance built with OUT_REG=1 is read one falling edge after its inputs were applied, after the next vector has already been driven, which shows the one-cycle delay.

// File: rtl/sshift_pkg.sv
package sshift_pkg;
  typedef enum logic [1:0] {
    OP_SHL  = 2'b00,
    OP_SHR  = 2'b01,
    OP_RSHR = 2'b10,
    OP_NORM = 2'b11
  } sshift_op_e;
endpackage

// File: rtl/sshift_norm.sv
// Redundant-sign-bit counter (R6): how far the word can move left without
// changing its sign bit. A zero word reports 0.
module sshift_norm #(
  parameter int W  = 32,
  localparam int NW = $clog2(W)
) (
  input  logic [W-1:0]  x,
  output logic [NW-1:0] nrm
);
  function automatic logic [NW-1:0] f_sign_run(logic [W-1:0] v);
    logic [NW-1:0] n;
    logic          run;
    n   = '0;
    run = 1'b1;
    for (int i = W - 2; i >= 0; i--) begin
      if (run && (v[i] == v[W-1])) n = n + 1'b1;
      else run = 1'b0;
    end
    if (v == '0) n = '0;
    return n;
  endfunction

  assign nrm = f_sign_run(x);
endmodule

// File: rtl/sshift_lane.sv
// One width lane: direction decode, saturating left path, arithmetic and
// rounding right paths, normalize.
module sshift_lane
  import sshift_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = 16,
  localparam int NW = $clog2(W),
  localparam int MW = CW + 1
) (
  input  logic [W-1:0]  x,
  input  logic [CW-1:0] cnt,
  input  sshift_op_e    op,
  output logic [W-1:0]  y,
  output logic          sat
);
  localparam logic [W-1:0] VMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] VMIN = {1'b1, {(W-1){1'b0}}};

  logic          neg, zero_cnt, zero_x, go_left;
  logic [MW-1:0] mag, ext;
  logic [NW-1:0] nrm;
  logic [W-1:0]  left_val;

  sshift_norm #(.W(W)) u_norm (.x(x), .nrm(nrm));

  // arithmetic right shift, amount clamped to W-1 (R3, R7)
  function automatic logic [W-1:0] f_asr(logic [W-1:0] v, logic [MW-1:0] amt);
    logic signed [W-1:0] s;
    logic [MW-1:0]       a;
    a = (amt > MW'(W - 1)) ? MW'(W - 1) : amt;
    s = v;
    return s >>> a;
  endfunction

  // round half up: shift by amt-1, then by one more plus the dropped bit (R4)
  function automatic logic [W-1:0] f_round(logic [W-1:0] v, logic [MW-1:0] amt);
    logic signed [W-1:0] s, x2, h;
    logic [MW-1:0]       a;
    a  = amt - 1'b1;
    a  = (a > MW'(W - 1)) ? MW'(W - 1) : a;
    s  = v;
    x2 = s >>> a;
    h  = x2 >>> 1;
    return h + {{(W-1){1'b0}}, x2[0]};
  endfunction

  always_comb begin
    neg      = cnt[CW-1];
    ext      = {cnt[CW-1], cnt};
    mag      = neg ? (~ext + 1'b1) : ext;
    zero_cnt = (cnt == '0);
    zero_x   = (x == '0);
    unique case (op)
      OP_SHL:  go_left = !neg && !zero_cnt;
      OP_SHR:  go_left = neg;
      OP_RSHR: go_left = neg;
      default: go_left = 1'b0;
    endcase
    // saturate once the move exceeds the redundant sign bits (R2)
    sat = go_left && !zero_x && (mag > MW'(nrm));
    if (zero_x)   left_val = '0;
    else if (sat) left_val = x[W-1] ? VMIN : VMAX;
    else          left_val = x << mag[NW-1:0];
    unique case (op)
      OP_SHL, OP_SHR: y = go_left ? left_val : f_asr(x, mag);
      OP_RSHR: begin
        if (zero_cnt || zero_x) y = x;          // R5
        else if (go_left)       y = left_val;
        else                    y = f_round(x, mag);
      end
      default: y = W'(nrm);                     // R6
    endcase
  end
endmodule

// File: rtl/sshift_unit.sv
module sshift_unit
  import sshift_pkg::*;
#(
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32,
  parameter int CNT_W    = 16,
  parameter bit OUT_REG  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_ovf,
  input  logic [2:0]        op,
  input  logic [WIDE_W-1:0] operand,
  input  logic [CNT_W-1:0]  count,
  output logic [WIDE_W-1:0] result,
  output logic              ovf
);
  localparam int LANES = 2;
  localparam logic [WIDE_W-1:0] W_MAX = {1'b0, {(WIDE_W-1){1'b1}}};
  localparam logic [WIDE_W-1:0] W_MIN = {1'b1, {(WIDE_W-1){1'b0}}};
  localparam logic [WIDE_W-1:0] N_MAX = WIDE_W'({1'b0, {(NARROW_W-1){1'b1}}});
  localparam logic [WIDE_W-1:0] N_MIN = {{(WIDE_W-NARROW_W+1){1'b1}}, {(NARROW_W-1){1'b0}}};

  logic [WIDE_W-1:0] lane_y [LANES];
  logic [LANES-1:0]  lane_sat;
  logic              sel_wide;
  logic [WIDE_W-1:0] res_c;
  logic              sat_evt;   // saturation present this cycle
  logic              opnd_zero;

  // lane 0 narrow, lane 1 wide; results sign-extended (R1, R11)
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int LW = (g == 0) ? NARROW_W : WIDE_W;
    logic [LW-1:0] y_l;
    sshift_lane #(.W(LW), .CW(CNT_W)) u_lane (
      .x   (operand[LW-1:0]),
      .cnt (count),
      .op  (sshift_op_e'(op[1:0])),
      .y   (y_l),
      .sat (lane_sat[g])
    );
    assign lane_y[g] = WIDE_W'($signed(y_l));
  end

  assign sel_wide  = op[2];
  assign res_c     = lane_y[sel_wide];
  assign sat_evt   = lane_sat[sel_wide];
  assign opnd_zero = sel_wide ? (operand == '0) : (operand[NARROW_W-1:0] == '0);

  // sticky flag: set has priority over clear (R8, R9, R10)
  always_ff @(posedge clk) begin
    if (!rst_n)       ovf <= 1'b0;
    else if (sat_evt) ovf <= 1'b1;
    else if (clr_ovf) ovf <= 1'b0;
  end

  if (OUT_REG) begin : g_oreg
    always_ff @(posedge clk) begin
      if (!rst_n) result <= '0;
      else        result <= res_c;
    end
  end else begin : g_comb
    assign result = res_c;
  end

  p_sat_extreme_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sat_evt |-> (sel_wide ? (res_c == W_MAX || res_c == W_MIN)
                          : (res_c == N_MAX || res_c == N_MIN)));
  p_zero_operand_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (opnd_zero && op[1:0] != 2'b11) |-> (res_c == '0 && !sat_evt));
  p_norm_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op[1:0] == 2'b11) |-> (res_c < (sel_wide ? WIDE_W : NARROW_W)));
  p_sticky_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sat_evt |=> ovf);
  p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr_ovf) |=> ovf);
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf && !sat_evt) |=> !ovf);
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovf && !sat_evt) |=> !ovf);
endmodule

// File: tb/tb_sshift_unit.sv
module tb_sshift_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_ovf = 1'b0;
  logic [2:0]  op = 3'b111;
  logic [31:0] operand = '0;
  logic [15:0] count = '0;
  logic [31:0] result, result_q;
  logic        ovf, ovf_q;
  int          n_chk = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;   // 50 MHz

  sshift_unit dut (.clk(clk), .rst_n(rst_n), .clr_ovf(clr_ovf), .op(op),
    .operand(operand), .count(count), .result(result), .ovf(ovf));
  sshift_unit #(.OUT_REG(1'b1)) dut_q (.clk(clk), .rst_n(rst_n), .clr_ovf(clr_ovf),
    .op(op), .operand(operand), .count(count), .result(result_q), .ovf(ovf_q));

  // {op, operand, count, expected result, expected saturation}
  localparam int NV = 37;
  localparam logic [83:0] VEC [NV] = '{
    {3'b100, 32'h00000001, 16'd4,    32'h00000010, 1'b0},  // R2
    {3'b100, 32'h40000000, 16'd1,    32'h7FFFFFFF, 1'b1},  // R2
    {3'b100, 32'hFFFFFFFF, 16'd31,   32'h80000000, 1'b0},  // R2
    {3'b100, 32'h80000001, 16'd1,    32'h80000000, 1'b1},  // R2
    {3'b100, 32'h12345678, 16'hFFFC, 32'h01234567, 1'b0},  // R3
    {3'b101, 32'h80000000, 16'd100,  32'hFFFFFFFF, 1'b0},  // R3
    {3'b101, 32'h7FFFFFFF, 16'd31,   32'h00000000, 1'b0},  // R3
    {3'b101, 32'h00000003, 16'hFFE3, 32'h60000000, 1'b0},  // R2
    {3'b101, 32'h00000003, 16'hFFE2, 32'h7FFFFFFF, 1'b1},  // R2
    {3'b110, 32'h00000005, 16'd1,    32'h00000003, 1'b0},  // R4
    {3'b110, 32'hFFFFFFFB, 16'd1,    32'hFFFFFFFE, 1'b0},  // R4
    {3'b110, 32'h7FFFFFFF, 16'd32,   32'h00000000, 1'b0},  // R4
    {3'b110, 32'h80000000, 16'd32,   32'h00000000, 1'b0},  // R4
    {3'b110, 32'h80000000, 16'd31,   32'hFFFFFFFF, 1'b0},  // R4
    {3'b110, 32'h12345678, 16'd0,    32'h12345678, 1'b0},  // R5
    {3'b110, 32'h00000000, 16'hFFFB, 32'h00000000, 1'b0},  // R5
    {3'b110, 32'h00010000, 16'hFFFE, 32'h00040000, 1'b0},  // R2
    {3'b111, 32'h00000001, 16'd0,    32'h0000001E, 1'b0},  // R6
    {3'b111, 32'h00000000, 16'd0,    32'h00000000, 1'b0},  // R6
    {3'b111, 32'hFFFFFFFF, 16'd0,    32'h0000001F, 1'b0},  // R6
    {3'b111, 32'hC0000000, 16'd0,    32'h00000001, 1'b0},  // R6
    {3'b100, 32'h00000001, 16'h8000, 32'h00000000, 1'b0},  // R7
    {3'b101, 32'h00000001, 16'h8000, 32'h7FFFFFFF, 1'b1},  // R7
    {3'b000, 32'hABCD0123, 16'd2,    32'h0000048C, 1'b0},  // R1
    {3'b000, 32'h00004000, 16'd1,    32'h00007FFF, 1'b1},  // R11
    {3'b000, 32'h0000C000, 16'd2,    32'hFFFF8000, 1'b1},  // R11
    {3'b000, 32'h0000C000, 16'd1,    32'hFFFF8000, 1'b0},  // R2
    {3'b001, 32'h00008000, 16'd3,    32'hFFFFF000, 1'b0},  // R3
    {3'b001, 32'h00008000, 16'd20,   32'hFFFFFFFF, 1'b0},  // R3
    {3'b010, 32'h00007FFF, 16'd1,    32'h00004000, 1'b0},  // R4
    {3'b010, 32'h00000003, 16'd2,    32'h00000001, 1'b0},  // R4
    {3'b010, 32'h00007FFF, 16'd16,   32'h00000000, 1'b0},  // R4
    {3'b011, 32'hFFFF0001, 16'd0,    32'h0000000E, 1'b0},  // R6
    {3'b011, 32'h0000FFFF, 16'd0,    32'h0000000F, 1'b0},  // R6
    {3'b011, 32'h00010000, 16'd0,    32'h00000000, 1'b0},  // R1
    {3'b001, 32'h00000001, 16'hFFF1, 32'h00007FFF, 1'b1},  // R11
    {3'b001, 32'h00000001, 16'hFFF2, 32'h00004000, 1'b0}   // R2
  };

  function automatic string tag_of(logic [2:0] o, logic [15:0] c, logic s);
    if (c == 16'h8000)   return "R7";
    if (s && !o[2])      return "R11";
    case (o[1:0])
      2'b11:   return "R6";
      2'b10:   return (c == 0) ? "R5" : (c[15] ? "R2" : "R4");
      2'b01:   return c[15] ? "R2" : "R3";
      default: return (c[15] || c == 0) ? "R3" : "R2";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [2:0] o, logic [31:0] x, logic [15:0] c, logic clr);
    op = o; operand = x; count = c; clr_ovf = clr;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", {31'b0, ovf}, 32'h0);        // reset state of flag
    chk("R10", result_q, 32'h0);            // reset state of result register
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [83:0] v;
      v = VEC[i];
      @(negedge clk); apply(3'b111, 32'h0, 16'h0, 1'b1);
      @(negedge clk); apply(v[83:81], v[80:49], v[48:33], 1'b0);
      #2 chk(tag_of(v[83:81], v[48:33], v[0]), result, v[32:1]);
      @(negedge clk);
      chk("R8", {31'b0, ovf}, {31'b0, v[0]});
    end

    // R1: same operand, width select changes the result
    @(negedge clk); apply(3'b001, 32'h00008000, 16'd0, 1'b0);
    #2 chk("R1", result, 32'hFFFF8000);
    @(negedge clk); apply(3'b101, 32'h00008000, 16'd0, 1'b0);
    #2 chk("R1", result, 32'h00008000);

    // R8: flag holds through non-saturating work
    @(negedge clk); apply(3'b100, 32'h40000000, 16'd3, 1'b0);
    @(negedge clk); apply(3'b101, 32'h00000100, 16'd2, 1'b0);
    repeat (3) @(negedge clk);
    chk("R8", {31'b0, ovf}, 32'h1);

    // R9: set wins over a simultaneous clear, plain clear empties the flag
    apply(3'b000, 32'h00007000, 16'd4, 1'b1);
    @(negedge clk);
    chk("R9", {31'b0, ovf}, 32'h1);
    apply(3'b000, 32'h00000001, 16'd1, 1'b1);
    @(negedge clk);
    chk("R9", {31'b0, ovf}, 32'h0);

    // R10: reset clears a set flag
    apply(3'b100, 32'h7FFFFFFF, 16'd5, 1'b0);
    @(negedge clk);
    chk("R8", {31'b0, ovf}, 32'h1);
    rst_n = 1'b0; apply(3'b111, 32'h0, 16'h0, 1'b0);
    @(negedge clk);
    chk("R10", {31'b0, ovf}, 32'h0);
    rst_n = 1'b1;

    // R10: registered variant lags by one clock
    @(negedge clk); apply(3'b101, 32'h00000010, 16'd4, 1'b0);
    @(negedge clk); apply(3'b101, 32'h00000100, 16'd4, 1'b0);
    #2 chk("R10", result_q, 32'h00000001);
    chk("R10", result, 32'h00000010);
    @(negedge clk);
    chk("R10", result_q, 32'h00000010);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule